// File: doc/BRIEF.md
# Double-Buffered Score Column Store

This block is the score storage of one cell in a folded systolic array. In such an array a query longer than the array is aligned in several passes, and each pass needs a different substitution-score column in the cell. The store holds exactly two column elements. One is the active element, which answers score look-ups indexed by subject residue for the pass in progress. The other is the shadow element, which is filled serially with the column for the following pass while the current pass runs. A small pass controller exchanges the two roles at each pass boundary, so most column loading is hidden behind computation.

A pass begins on a start request. If the shadow column is complete, the roles swap at once and the request is acknowledged. If it is not complete, the request waits and a not-ready flag is raised until the last entry arrives. A done pulse closes the running pass. After a swap, the element that was freed is marked empty and its serial write position goes back to index 0. The newly active element takes no writes until the next swap.

Top module: `score_col_pingpong`

## Requirements
- R1: After reset, rd_valid_o, pass_ack_o, not_ready_o, pass_busy_o, shadow_full_o and active_sel_o are all 0, and no element is active.
- R2: Each accepted write stores wr_data_i into the shadow element at the next index, starting at 0 and rising by one per write. After COL_DEPTH (32) writes, shadow_full_o becomes 1 in the following cycle.
- R3: A write while shadow_full_o is 1 is ignored and changes no stored entry. shadow_full_o falls only in the cycle pass_ack_o is high.
- R4: A pass_start_i pulse with no pass running and a full shadow gives a one-cycle pass_ack_o in the next cycle, with pass_busy_o high from that cycle on.
- R5: A pass_start_i pulse with the shadow not full raises not_ready_o in the next cycle with no swap. When the shadow becomes full, the swap happens on the next edge, and pass_ack_o rises in the same cycle that not_ready_o falls.
- R6: In the cycle pass_ack_o is high, shadow_full_o is 0, because the freed element is empty. The next write lands at index 0 of that element.
- R7: With an element active, a read request (rd_en_i, rd_idx_i) in cycle t gives rd_valid_o=1 and the active element's entry in cycle t+1. Before the first swap, reads give rd_valid_o=0.
- R8: Writing the shadow element in the same cycles as reads of the active element does not alter the data that is read.
- R9: pass_start_i while a pass is running has no effect. pass_done_i ends a running pass (pass_busy_o=0 next cycle). pass_done_i with no pass running has no effect.
- R10: active_sel_o (0 = element 0, 1 = element 1) toggles on every swap and changes at no other time. The first swap selects element 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Serial write strobe for the shadow element |
| wr_data_i | input | SCORE_W | Score written at the next shadow index |
| rd_en_i | input | 1 | Read request to the active element |
| rd_idx_i | input | IDX_W | Subject residue index to read |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| rd_data_o | output | SCORE_W | Score read from the active element |
| pass_start_i | input | 1 | Request to begin the next pass |
| pass_done_i | input | 1 | The running pass has finished |
| pass_ack_o | output | 1 | One-cycle pulse: roles swapped, pass begun |
| not_ready_o | output | 1 | A start request is stalled on an incomplete shadow |
| pass_busy_o | output | 1 | A pass is running |
| shadow_full_o | output | 1 | The shadow element holds a complete column |
| active_sel_o | output | 1 | Index of the active element |

## Verification
The hardest case to reach is a start request that arrives while the shadow column is only partly loaded. The swap must stall, then fire on exactly the edge after the final entry lands, and not_ready_o must fall together with the acknowledge. The stimulus ends one pass early with the freed element empty, issues the start, reads the still-active column during the stall, and then feeds the column one entry at a time. Timing checks cover the cycle the last entry lands and the cycle after. A second hard case is overlap: shadow writes and active reads are driven in the same cycles across a full column, and a scoreboard checks every returned score against the column that should be active.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int NUM_ELEM = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   active;
        logic   has_active;
        logic   ack;
    } ctrl_s;

endpackage

// File: rtl/scp_column.sv
module scp_column #(
    parameter int COL_DEPTH = 32,
    parameter int SCORE_W   = 8,
    localparam int IDX_W    = $clog2(COL_DEPTH)
) (
    input  logic               clk,
    input  logic               we_i,
    input  logic [IDX_W-1:0]   waddr_i,
    input  logic [SCORE_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]   raddr_i,
    output logic [SCORE_W-1:0] rdata_o
);

    logic [SCORE_W-1:0] mem_q [COL_DEPTH];
    logic [SCORE_W-1:0] mem_d [COL_DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/scp_fill_track.sv
module scp_fill_track #(
    parameter int COL_DEPTH = 32,
    localparam int IDX_W    = $clog2(COL_DEPTH),
    localparam int NELEM    = scp_pkg::NUM_ELEM
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             swap_i,
    input  logic             shadow_sel_i,
    output logic             accept_o,
    output logic [IDX_W-1:0] wr_ptr_o,
    output logic             shadow_full_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(COL_DEPTH - 1);

    typedef struct packed {
        logic [IDX_W-1:0] ptr;
        logic [NELEM-1:0] full;
    } fill_s;

    fill_s st_q, st_d;
    logic  accept;

    always_comb begin
        st_d   = st_q;
        accept = wr_en_i && !st_q.full[shadow_sel_i];
        if (accept) begin
            if (st_q.ptr == LAST_IDX) begin
                st_d.ptr                 = '0;
                st_d.full[shadow_sel_i]  = 1'b1;
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
        if (swap_i) begin
            st_d.full[~shadow_sel_i] = 1'b0;
            st_d.ptr                 = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept_o      = accept;
    assign wr_ptr_o      = st_q.ptr;
    assign shadow_full_o = st_q.full[shadow_sel_i];

endmodule

// File: rtl/scp_pass_ctrl.sv
module scp_pass_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic pass_start_i,
    input  logic pass_done_i,
    input  logic shadow_full_i,
    output logic swap_o,
    output logic active_o,
    output logic has_active_o,
    output logic ack_o,
    output logic not_ready_o,
    output logic busy_o
);

    import scp_pkg::*;

    ctrl_s st_q, st_d;
    logic  swap;

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        swap     = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (pass_start_i) begin
                    if (shadow_full_i) begin
                        swap       = 1'b1;
                        st_d.phase = PH_RUN;
                    end else begin
                        st_d.phase = PH_WAIT;
                    end
                end
            end
            PH_WAIT: begin
                if (shadow_full_i) begin
                    swap       = 1'b1;
                    st_d.phase = PH_RUN;
                end
            end
            PH_RUN: begin
                if (pass_done_i) begin
                    st_d.phase = PH_IDLE;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
        if (swap) begin
            st_d.active     = ~st_q.active;
            st_d.has_active = 1'b1;
            st_d.ack        = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, active: 1'b0, has_active: 1'b0, ack: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign swap_o       = swap;
    assign active_o     = st_q.active;
    assign has_active_o = st_q.has_active;
    assign ack_o        = st_q.ack;
    assign not_ready_o  = (st_q.phase == PH_WAIT);
    assign busy_o       = (st_q.phase == PH_RUN);

endmodule

// File: rtl/score_col_pingpong.sv
module score_col_pingpong #(
    parameter int COL_DEPTH = 32,
    parameter int SCORE_W   = 8,
    localparam int IDX_W    = $clog2(COL_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [SCORE_W-1:0] wr_data_i,
    input  logic               rd_en_i,
    input  logic [IDX_W-1:0]   rd_idx_i,
    output logic               rd_valid_o,
    output logic [SCORE_W-1:0] rd_data_o,
    input  logic               pass_start_i,
    input  logic               pass_done_i,
    output logic               pass_ack_o,
    output logic               not_ready_o,
    output logic               pass_busy_o,
    output logic               shadow_full_o,
    output logic               active_sel_o
);

    localparam int NELEM = scp_pkg::NUM_ELEM;

    typedef struct packed {
        logic               valid;
        logic [SCORE_W-1:0] data;
    } rd_s;

    logic               swap;
    logic               active;
    logic               has_active;
    logic               shadow_full;
    logic               accept;
    logic [IDX_W-1:0]   wr_ptr;
    logic [SCORE_W-1:0] col_rd [NELEM];
    rd_s                rd_q, rd_d;

    scp_pass_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .pass_start_i  (pass_start_i),
        .pass_done_i   (pass_done_i),
        .shadow_full_i (shadow_full),
        .swap_o        (swap),
        .active_o      (active),
        .has_active_o  (has_active),
        .ack_o         (pass_ack_o),
        .not_ready_o   (not_ready_o),
        .busy_o        (pass_busy_o)
    );

    scp_fill_track #(
        .COL_DEPTH (COL_DEPTH)
    ) u_fill (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en_i),
        .swap_i        (swap),
        .shadow_sel_i  (~active),
        .accept_o      (accept),
        .wr_ptr_o      (wr_ptr),
        .shadow_full_o (shadow_full)
    );

    for (genvar k = 0; k < NELEM; k++) begin : g_elem
        logic elem_we;
        assign elem_we = accept && (active != 1'(k));
        scp_column #(
            .COL_DEPTH (COL_DEPTH),
            .SCORE_W   (SCORE_W)
        ) u_col (
            .clk     (clk),
            .we_i    (elem_we),
            .waddr_i (wr_ptr),
            .wdata_i (wr_data_i),
            .raddr_i (rd_idx_i),
            .rdata_o (col_rd[k])
        );
    end

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = rd_en_i && has_active;
        if (rd_en_i && has_active) begin
            rd_d.data = col_rd[active];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid_o    = rd_q.valid;
    assign rd_data_o     = rd_q.data;
    assign shadow_full_o = shadow_full;
    assign active_sel_o  = active;

endmodule

// File: rtl/scp_checker.sv
module scp_checker (
    input logic clk,
    input logic rst_n,
    input logic rd_en_i,
    input logic rd_valid_o,
    input logic pass_ack_o,
    input logic not_ready_o,
    input logic pass_busy_o,
    input logic shadow_full_o,
    input logic active_sel_o
);

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pass_ack_o |=> !pass_ack_o); // R4

    AST_ACK_STARTS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        pass_ack_o |-> pass_busy_o); // R4

    AST_SWAP_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        pass_ack_o |-> $past(shadow_full_o)); // R5

    AST_STALL_EXIT_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(not_ready_o) |-> pass_ack_o); // R5

    AST_FREED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pass_ack_o |-> !shadow_full_o); // R6

    AST_FULL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shadow_full_o) |-> pass_ack_o); // R3

    AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(rd_en_i)); // R7

    AST_SEL_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        pass_ack_o |-> (active_sel_o != $past(active_sel_o))); // R10

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !pass_ack_o |-> $stable(active_sel_o)); // R10

    AST_STALL_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        not_ready_o |-> !pass_busy_o); // R9

endmodule

bind score_col_pingpong scp_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_en_i       (rd_en_i),
    .rd_valid_o    (rd_valid_o),
    .pass_ack_o    (pass_ack_o),
    .not_ready_o   (not_ready_o),
    .pass_busy_o   (pass_busy_o),
    .shadow_full_o (shadow_full_o),
    .active_sel_o  (active_sel_o)
);

// File: tb/score_col_pingpong_test.sv
module score_col_pingpong_test;

    localparam int DEPTH = 32;
    localparam int W     = 8;
    localparam int IW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic          rd_en = 1'b0;
    logic [IW-1:0] rd_idx = '0;
    logic          rd_valid;
    logic [W-1:0]  rd_data;
    logic          pass_start = 1'b0;
    logic          pass_done = 1'b0;
    logic          pass_ack;
    logic          not_ready;
    logic          pass_busy;
    logic          shadow_full;
    logic          active_sel;

    always #4 clk = ~clk;

    score_col_pingpong #(.COL_DEPTH(DEPTH), .SCORE_W(W)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en),
        .wr_data_i     (wr_data),
        .rd_en_i       (rd_en),
        .rd_idx_i      (rd_idx),
        .rd_valid_o    (rd_valid),
        .rd_data_o     (rd_data),
        .pass_start_i  (pass_start),
        .pass_done_i   (pass_done),
        .pass_ack_o    (pass_ack),
        .not_ready_o   (not_ready),
        .pass_busy_o   (pass_busy),
        .shadow_full_o (shadow_full),
        .active_sel_o  (active_sel)
    );

    int           n_tests = 0;
    int           n_fail  = 0;
    logic [W-1:0] model [2][DEPTH];
    int           model_act = 0;
    bit           have_act  = 1'b0;
    int           wr_pos    = 0;
    logic [W-1:0] exp_q [$];
    string        tag_q [$];

    task automatic check_eq(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one cycle of stimulus, applied at a falling edge
    task automatic step(logic we, logic [W-1:0] wd, logic re, logic [IW-1:0] ri,
                        logic ps, logic pd, string rtag);
        wr_en      = we;
        wr_data    = wd;
        rd_en      = re;
        rd_idx     = ri;
        pass_start = ps;
        pass_done  = pd;
        if (re && have_act) begin
            exp_q.push_back(model[model_act][ri]);
            tag_q.push_back(rtag);
        end
        @(negedge clk);
        wr_en      = 1'b0;
        rd_en      = 1'b0;
        pass_start = 1'b0;
        pass_done  = 1'b0;
    endtask

    // shadow write, with the bench model of the serial index
    task automatic wr_shadow(logic [W-1:0] d, logic re, logic [IW-1:0] ri, string rtag);
        model[1 - model_act][wr_pos] = d;
        wr_pos++;
        step(1'b1, d, re, ri, 1'b0, 1'b0, rtag);
    endtask

    task automatic read_all(string rtag);
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b0, '0, 1'b1, IW'(i), 1'b0, 1'b0, rtag);
        end
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "");
    endtask

    task automatic did_swap();
        model_act = 1 - model_act;
        have_act  = 1'b1;
        wr_pos    = 0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_tests++;
                n_fail++;
                $display("FAIL R7: actual unexpected read data %0d expected no valid", rd_data);
            end else begin
                logic [W-1:0] e;
                string        t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check_eq(t, int'(rd_data), int'(e));
            end
        end
    end

    initial begin
        #(8 * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_eq("R1 rd_valid", int'(rd_valid), 0);
        check_eq("R1 pass_ack", int'(pass_ack), 0);
        check_eq("R1 not_ready", int'(not_ready), 0);
        check_eq("R1 pass_busy", int'(pass_busy), 0);
        check_eq("R1 shadow_full", int'(shadow_full), 0);
        check_eq("R1 active_sel", int'(active_sel), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // read before any element is active
        step(1'b0, '0, 1'b1, IW'(3), 1'b0, 1'b0, "R7");
        check_eq("R7 no valid before first swap", int'(rd_valid), 0);

        // column A into element 1
        for (int i = 0; i < DEPTH - 1; i++) wr_shadow(W'(i * 7 + 3), 1'b0, '0, "");
        check_eq("R2 not full after 31 writes", int'(shadow_full), 0);
        wr_shadow(W'((DEPTH - 1) * 7 + 3), 1'b0, '0, "");
        check_eq("R2 full after 32 writes", int'(shadow_full), 1);

        // write while full must be dropped
        step(1'b1, 8'hEE, 1'b0, '0, 1'b0, 1'b0, "");
        check_eq("R3 full held", int'(shadow_full), 1);

        // first pass start with a full shadow
        step(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, "");
        check_eq("R4 ack", int'(pass_ack), 1);
        check_eq("R4 busy", int'(pass_busy), 1);
        check_eq("R10 first select", int'(active_sel), 1);
        check_eq("R6 freed empty", int'(shadow_full), 0);
        did_swap();
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "");
        check_eq("R4 ack one cycle", int'(pass_ack), 0);
        read_all("R2 R3 R7 column A");

        // overlap: column B into element 0 while reading element 1
        for (int i = 0; i < DEPTH; i++) wr_shadow(W'(255 - i * 5), 1'b1, IW'(DEPTH - 1 - i), "R8 overlap read");
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "");
        check_eq("R8 shadow full after overlap", int'(shadow_full), 1);

        // start while running is ignored
        step(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, "");
        check_eq("R9 no ack while busy", int'(pass_ack), 0);
        check_eq("R9 select held", int'(active_sel), 1);
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b1, "");
        check_eq("R9 done clears busy", int'(pass_busy), 0);
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b1, "");
        check_eq("R9 idle done busy", int'(pass_busy), 0);
        check_eq("R9 idle done select", int'(active_sel), 1);

        // second pass
        step(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, "");
        check_eq("R10 toggles back", int'(active_sel), 0);
        check_eq("R4 ack second", int'(pass_ack), 1);
        did_swap();
        read_all("R6 column B from index 0");

        // stalled start on an empty shadow
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b1, "");
        step(1'b0, '0, 1'b0, '0, 1'b1, 1'b0, "");
        check_eq("R5 not_ready raised", int'(not_ready), 1);
        check_eq("R5 no ack on stall", int'(pass_ack), 0);
        check_eq("R5 not busy in stall", int'(pass_busy), 0);
        step(1'b0, '0, 1'b1, IW'(9), 1'b0, 1'b0, "R5 read during stall");
        for (int i = 0; i < DEPTH - 1; i++) wr_shadow(W'(i * 11 + 1), 1'b0, '0, "");
        check_eq("R5 still stalled", int'(not_ready), 1);
        wr_shadow(W'((DEPTH - 1) * 11 + 1), 1'b0, '0, "");
        check_eq("R5 full on last entry", int'(shadow_full), 1);
        check_eq("R5 no ack yet", int'(pass_ack), 0);
        check_eq("R5 not_ready at last entry", int'(not_ready), 1);
        step(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "");
        check_eq("R5 ack after fill", int'(pass_ack), 1);
        check_eq("R5 not_ready cleared", int'(not_ready), 0);
        check_eq("R10 third select", int'(active_sel), 1);
        did_swap();
        read_all("R5 column C");

        repeat (3) @(negedge clk);
        check_eq("R7 all reads returned", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule